// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs one 8-bit peripheral port in strobed mode, in either direction, and uses dedicated handshake lines for the exchange. In the input direction, a peripheral pulls its strobe low to capture the port data into a holding register. The block then raises a buffer-full flag. When the strobe returns high and the enable flop is set, it raises an interrupt. A CPU read of the port empties the buffer and drops the interrupt. In the output direction, the end of a CPU write latches the data onto the port and pulls the active-low output-full line. The peripheral answers with a low acknowledge, which releases that line. Once the acknowledge is back high, with the enable flop set and no write in progress, the interrupt rises. The start of the next CPU write clears it.

The direction is chosen by a configuration write. That write also clears every status flop and the interrupt enable. The enable flop can only be changed by a single-bit set/reset command that addresses the port-C bit position given by a parameter. Commands for any other bit position leave it alone. The CPU strobes are synchronous to the clock and already decoded. The peripheral strobe and acknowledge pass through a two-stage synchronizer before their edges are detected. The handshake is a plain level protocol, so there is no valid/ready pair: the peripheral applies back-pressure by holding off its strobe or its acknowledge until the flags allow it.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset the direction is input, `ibf` is 0, `obf_n` is 1, `intr` is 0, `per_dout` is 0 and the enable flop is clear.
- R2: In input direction (`cfg_dir_in`=1 last written), a synchronized falling edge of `stb_n` loads `per_din` into the holding register and sets `ibf`. `cpu_rdata` shows the held byte.
- R3: In input direction, a falling edge of `cpu_rd_n` clears `ibf` and the input interrupt on the next clock.
- R4: In input direction, a synchronized rising edge of `stb_n` while `ibf` is 1 and the enable flop is 1 sets `intr`.
- R5: In output direction, a rising edge of `cpu_wr_n` latches `cpu_wdata` onto `per_dout` and drives `obf_n` to 0 on the next clock.
- R6: A synchronized falling edge of `ack_n` returns `obf_n` to 1, unless a write ends in the same cycle.
- R7: In output direction, `intr` rises when the synchronized `ack_n` is 1, `obf_n` is 1, the enable flop is 1 and `cpu_wr_n` has been high for two cycles. A falling edge of `cpu_wr_n` clears `intr`.
- R8: `bsr_wr` with `bsr_sel` equal to `EN_BIT` (default 4) writes `bsr_val` into the enable flop. `bsr_wr` with any other `bsr_sel` has no effect on it.
- R9: `cfg_wr` sets the direction from `cfg_dir_in` and clears the enable flop, `ibf`, the interrupt and the holding register, and returns `obf_n` to 1.
- R10: Strobes have no effect in output direction (`ibf` stays 0), and writes have no effect on `obf_n` in input direction (it stays 1).
- R11: `intr` is 0 whenever the enable flop is clear. Clearing the flop drops a pending interrupt at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_dir_in | input | 1 | Direction for cfg_wr: 1 input, 0 output |
| bsr_wr | input | 1 | Single-bit set/reset command pulse |
| bsr_sel | input | 3 | Port-C bit position addressed by the command |
| bsr_val | input | 1 | Value written to the addressed bit |
| cpu_rd_n | input | 1 | CPU read strobe of the port, active low |
| cpu_wr_n | input | 1 | CPU write strobe of the port, active low |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Held input byte (input direction) or output latch |
| per_din | input | 8 | Peripheral data into the port |
| per_dout | output | 8 | Output latch toward the peripheral |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
The properties assume that `cfg_wr` and `bsr_wr` are single-cycle pulses that never coincide with a CPU strobe edge. They also assume that `per_din` stays steady from the strobe falling until three clocks after it, and that each peripheral level is held for several clocks so the synchronizer sees every edge. The stimulus drives every input at the falling clock edge. It holds each strobe and acknowledge level for four clocks or more, and it issues configuration and set/reset commands only while both CPU strobes are idle high.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } port_dir_e;
endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for an idle-high asynchronous line, with edge pulses.
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic lvl,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_n};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign fall = last & ~lvl;
  assign rise = ~last & lvl;
endmodule

// File: rtl/hs_in_path.sv
// Strobed input side: holding register, buffer-full flag, input interrupt.
module hs_in_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          stb_fall,
  input  logic          stb_rise,
  input  logic          rd_fall,
  input  logic          inte,
  input  logic [DW-1:0] din,
  output logic          ibf,
  output logic          intr_raw,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ibf      <= 1'b0;
      intr_raw <= 1'b0;
      data     <= '0;
    end else if (clr) begin
      ibf      <= 1'b0;
      intr_raw <= 1'b0;
      data     <= '0;
    end else begin
      if (en && stb_fall) begin
        ibf  <= 1'b1;
        data <= din;
      end else if (rd_fall) begin
        ibf <= 1'b0;
      end
      if (en && stb_rise && ibf && inte) begin
        intr_raw <= 1'b1;
      end else if (rd_fall) begin
        intr_raw <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_out_path.sv
// Strobed output side: output latch, active-low full flag, output interrupt.
module hs_out_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic          wr_idle,
  input  logic          ack_lvl,
  input  logic          ack_fall,
  input  logic          inte,
  input  logic [DW-1:0] wdata,
  output logic          obf_n,
  output logic          intr_raw,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      obf_n    <= 1'b1;
      intr_raw <= 1'b0;
      data     <= '0;
    end else if (clr) begin
      obf_n    <= 1'b1;
      intr_raw <= 1'b0;
      data     <= '0;
    end else begin
      if (en && wr_rise) begin
        obf_n <= 1'b0;
        data  <= wdata;
      end else if (ack_fall) begin
        obf_n <= 1'b1;
      end
      if (wr_fall) begin
        intr_raw <= 1'b0;
      end else if (en && ack_lvl && obf_n && inte && wr_idle) begin
        intr_raw <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_port_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          SEL_W       = 3,
  parameter int unsigned EN_BIT      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_dir_in,
  input  logic             bsr_wr,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_val,
  input  logic             cpu_rd_n,
  input  logic             cpu_wr_n,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [DW-1:0]    per_din,
  output logic [DW-1:0]    per_dout,
  input  logic             stb_n,
  input  logic             ack_n,
  output logic             ibf,
  output logic             obf_n,
  output logic             intr
);
  localparam logic [SEL_W-1:0] EN_SEL = SEL_W'(EN_BIT);

  port_dir_e     dir_q;
  logic          dir_is_in;
  logic          inte_q;
  logic          wr_d, rd_d;
  logic          wr_rise, wr_fall, wr_idle, rd_fall;
  logic          stb_lvl, stb_fall, stb_rise;
  logic          ack_lvl, ack_fall, ack_rise;
  logic          in_intr, out_intr;
  logic [DW-1:0] in_data, out_data;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dir_q  <= DIR_IN;
      inte_q <= 1'b0;
    end else if (cfg_wr) begin
      dir_q  <= cfg_dir_in ? DIR_IN : DIR_OUT;
      inte_q <= 1'b0;
    end else if (bsr_wr && (bsr_sel == EN_SEL)) begin
      inte_q <= bsr_val;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= cpu_wr_n;
      rd_d <= cpu_rd_n;
    end
  end

  assign dir_is_in = (dir_q == DIR_IN);
  assign wr_rise   = ~wr_d & cpu_wr_n;
  assign wr_fall   = wr_d & ~cpu_wr_n;
  assign wr_idle   = wr_d & cpu_wr_n;
  assign rd_fall   = rd_d & ~cpu_rd_n;

  hs_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst(rst), .async_n(stb_n),
    .lvl(stb_lvl), .fall(stb_fall), .rise(stb_rise)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .async_n(ack_n),
    .lvl(ack_lvl), .fall(ack_fall), .rise(ack_rise)
  );

  hs_in_path #(.DW(DW)) u_in (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(dir_is_in),
    .stb_fall(stb_fall), .stb_rise(stb_rise), .rd_fall(rd_fall),
    .inte(inte_q), .din(per_din),
    .ibf(ibf), .intr_raw(in_intr), .data(in_data)
  );

  hs_out_path #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(~dir_is_in),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .wr_idle(wr_idle),
    .ack_lvl(ack_lvl), .ack_fall(ack_fall), .inte(inte_q), .wdata(cpu_wdata),
    .obf_n(obf_n), .intr_raw(out_intr), .data(out_data)
  );

  assign intr      = inte_q & (dir_is_in ? in_intr : out_intr);
  assign cpu_rdata = dir_is_in ? in_data : out_data;
  assign per_dout  = out_data;
endmodule

// File: rtl/hs_port_ctrl_chk.sv
module hs_port_ctrl_chk #(
  parameter int          SEL_W  = 3,
  parameter int unsigned EN_BIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             bsr_wr,
  input logic [SEL_W-1:0] bsr_sel,
  input logic             cpu_rd_n,
  input logic             cpu_wr_n,
  input logic             ibf,
  input logic             obf_n,
  input logic             intr,
  input logic             dir_in,
  input logic             inte,
  input logic             stb_fall,
  input logic             ack_fall
);
  assert_strobe_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (dir_in && stb_fall && !cfg_wr) |=> ibf);

  assert_read_empties_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_rd_n) && !stb_fall && !cfg_wr) |=> !ibf);

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_wr_n) && !dir_in && !cfg_wr) |=> !obf_n);

  assert_ack_releases_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_fall && !$rose(cpu_wr_n)) |=> obf_n);

  assert_write_clears_intr_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_wr_n) && !dir_in) |=> !intr);

  assert_enable_source_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(inte) |-> ($past(bsr_wr) || $past(cfg_wr)));

  assert_other_bit_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (bsr_wr && (bsr_sel != SEL_W'(EN_BIT)) && !cfg_wr) |=> $stable(inte));

  assert_cfg_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (!inte && !ibf && obf_n && !intr));

  assert_no_ibf_output_R10: assert property (@(posedge clk) disable iff (rst)
    !dir_in |-> !ibf);

  assert_no_obf_input_R10: assert property (@(posedge clk) disable iff (rst)
    dir_in |-> obf_n);
endmodule

bind hs_port_ctrl hs_port_ctrl_chk #(.SEL_W(SEL_W), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .bsr_wr(bsr_wr), .bsr_sel(bsr_sel),
  .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .ibf(ibf), .obf_n(obf_n),
  .intr(intr), .dir_in(dir_is_in), .inte(inte_q),
  .stb_fall(stb_fall), .ack_fall(ack_fall)
);

// File: tb/test_hs_port_ctrl.sv
`timescale 1ns/1ps
module test_hs_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_dir_in = 1'b1;
  logic       bsr_wr = 1'b0, bsr_val = 1'b0;
  logic [2:0] bsr_sel = '0;
  logic       cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [7:0] cpu_wdata = '0, cpu_rdata, per_din = '0, per_dout;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic       ibf, obf_n, intr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hs_port_ctrl i_hs_port_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dir_in(cfg_dir_in),
    .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .per_din(per_din), .per_dout(per_dout),
    .stb_n(stb_n), .ack_n(ack_n), .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  // Scoreboard: 0 ibf, 1 obf_n, 2 intr, 3 cpu_rdata, 4 per_dout
  typedef struct {
    int         sig;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  function automatic logic [7:0] observe(int sig);
    case (sig)
      0: return {7'd0, ibf};
      1: return {7'd0, obf_n};
      2: return {7'd0, intr};
      3: return cpu_rdata;
      default: return per_dout;
    endcase
  endfunction

  task automatic expect_sig(int sig, logic [7:0] v, string tag);
    sb_q.push_back('{sig, v, tag});
  endtask

  always begin
    @(negedge clk);
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (observe(cur.sig) !== cur.exp) begin
        errors++;
        $display("FAIL %s: signal %0d actual %h expected %h", cur.tag, cur.sig,
                 observe(cur.sig), cur.exp);
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drv_bsr(logic [2:0] sel, logic val);
    @(negedge clk); bsr_wr = 1'b1; bsr_sel = sel; bsr_val = val;
    @(negedge clk); bsr_wr = 1'b0;
  endtask

  task automatic drv_cfg(logic din);
    @(negedge clk); cfg_wr = 1'b1; cfg_dir_in = din;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic drv_stb_low(logic [7:0] d);
    @(negedge clk); per_din = d; stb_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic drv_stb_high();
    @(negedge clk); stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drv_read();
    @(negedge clk); cpu_rd_n = 1'b0;
    @(negedge clk); cpu_rd_n = 1'b1;
  endtask

  task automatic drv_write(logic [7:0] d);
    @(negedge clk); cpu_wr_n = 1'b0; cpu_wdata = d;
    @(negedge clk); cpu_wr_n = 1'b1;
  endtask

  task automatic drv_ack(logic lvl);
    @(negedge clk); ack_n = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle(1);
    expect_sig(0, 8'h00, "R1 ibf"); expect_sig(1, 8'h01, "R1 obf_n");
    expect_sig(2, 8'h00, "R1 intr"); expect_sig(4, 8'h00, "R1 per_dout");

    // Input direction with enable set
    drv_bsr(3'd4, 1'b1);
    drv_stb_low(8'hA5);
    settle(1);
    expect_sig(0, 8'h01, "R2 ibf"); expect_sig(3, 8'hA5, "R2 data");
    expect_sig(2, 8'h00, "R4 no intr before strobe rise");
    drv_stb_high();
    settle(1);
    expect_sig(2, 8'h01, "R4 intr");
    drv_read();
    settle(1);
    expect_sig(0, 8'h00, "R3 ibf"); expect_sig(2, 8'h00, "R3 intr");

    // Enable cleared: no interrupt
    drv_bsr(3'd4, 1'b0);
    drv_stb_low(8'h3C);
    drv_stb_high();
    settle(1);
    expect_sig(3, 8'h3C, "R2 second byte"); expect_sig(2, 8'h00, "R11 intr gated");
    drv_read();

    // Wrong bit position ignored
    drv_bsr(3'd2, 1'b1);
    drv_stb_low(8'h5F);
    drv_stb_high();
    settle(1);
    expect_sig(2, 8'h00, "R8 other bit ignored");
    drv_read();

    // Enable then mode change clears it
    drv_bsr(3'd4, 1'b1);
    drv_cfg(1'b0);
    settle(1);
    expect_sig(0, 8'h00, "R9 ibf"); expect_sig(1, 8'h01, "R9 obf_n");
    expect_sig(2, 8'h00, "R9 intr enable cleared");
    settle(4);
    expect_sig(2, 8'h00, "R9 intr stays low");

    // Output direction
    drv_bsr(3'd4, 1'b1);
    settle(3);
    expect_sig(2, 8'h01, "R7 intr idle");
    drv_write(8'h5A);
    settle(1);
    expect_sig(1, 8'h00, "R5 obf_n"); expect_sig(4, 8'h5A, "R5 per_dout");
    expect_sig(2, 8'h00, "R7 intr cleared by write");
    drv_ack(1'b0);
    settle(1);
    expect_sig(1, 8'h01, "R6 obf_n released"); expect_sig(2, 8'h00, "R7 intr while ack low");
    drv_ack(1'b1);
    settle(1);
    expect_sig(2, 8'h01, "R7 intr after ack");

    // Strobe ignored in output direction
    drv_stb_low(8'hEE);
    drv_stb_high();
    settle(1);
    expect_sig(0, 8'h00, "R10 ibf in output"); expect_sig(4, 8'h5A, "R10 per_dout kept");

    // Clearing enable drops a pending interrupt
    drv_bsr(3'd4, 1'b0);
    settle(1);
    expect_sig(2, 8'h00, "R11 intr dropped");
    drv_write(8'h11);
    drv_ack(1'b0);
    drv_ack(1'b1);
    settle(1);
    expect_sig(1, 8'h01, "R6 second ack"); expect_sig(2, 8'h00, "R11 no intr");
    expect_sig(4, 8'h11, "R5 second byte");

    // Back to input, enable set before mode write
    drv_bsr(3'd4, 1'b1);
    drv_cfg(1'b1);
    drv_write(8'h77);
    settle(2);
    expect_sig(1, 8'h01, "R10 obf_n in input");
    drv_stb_low(8'h42);
    drv_stb_high();
    settle(1);
    expect_sig(0, 8'h01, "R2 ibf after mode change");
    expect_sig(2, 8'h00, "R9 enable cleared by mode write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule